// File: doc/BRIEF.md
# LCD Panel Control Registers with Glitch-Free Signal Gating

This block holds the settings a dot-matrix LCD controller needs from software and turns them into the signals the rest of the display path uses. Two byte-wide registers sit on a simple CPU bus. One holds the gating enables for the line clock and the frame signal. The other holds the 4-bit contrast code, the 2-bit display mode and the display-area select. Writes take effect on the next clock edge. Reads are combinational from the address.

The block also gates the raw line clock and frame timing signals onto their output pins. An enable change is applied only while the raw signal is high. As a result, a pin shows either a steady high or complete cycles of the raw signal, and never a cut-short pulse. A sleep request clears the display mode, blocks mode writes, and parks both pins high. The area select only has meaning at 1/16 and 1/8 duty. The contrast code is suppressed when the panel runs from an external supply.

Top module: `lcd_ctrl_regs`

## Requirements
- R1: A write to 0xFF11 stores bits 3:0 as contrast, bits 5:4 as mode and bit 6 as area select. A write to 0xFF10 stores bit 3 as the frame enable and bit 4 as the line-clock enable. A write to any other address changes no field.
- R2: A read of 0xFF11 or 0xFF10 returns the stored fields at the positions of R1 with every other bit 0. A read of any other address returns 0.
- R3: The `disp_mode` output shows the stored mode one cycle after the write. The codes are 00 drive off, 01 normal, 10 all dark (dynamic) and 11 all lit (static).
- R4: `area_sel` equals the stored area bit when `duty_sel` is 01 (1/16) or 10 (1/8). It is 0 when `duty_sel` is 00 (1/32) or 11 (reserved).
- R5: A pin whose enable bit is 0, or whose port bit input is 0, settles to a steady high within one raw period.
- R6: A pin that is enabled, with its port bit at 1 and no sleep, follows its raw signal one clock later.
- R7: A change in a gate's effective enable takes hold only while the raw signal is high. Every low phase a pin shows is a complete raw low phase: 4 cycles for a raw line clock of period 8, and 16 cycles for a raw frame signal of period 32.
- R8: While `sleep_req` is 1, the stored mode is 00 and mode writes are dropped. Contrast and area writes are still stored. After sleep ends, the mode stays 00 until software writes it.
- R9: During sleep, both pins reach a steady high within one raw period. They resume following their raw signals after sleep ends.
- R10: With `ext_supply` at 1, the `contrast` output is 0 while the stored code stays readable. With `ext_supply` at 0, the output equals the stored code.
- R11: Under reset, every field is 0, both pins are high and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sleep_req | input | 1 | Sleep state |
| duty_sel | input | 2 | Duty: 00 1/32, 01 1/16, 10 1/8, 11 reserved |
| ext_supply | input | 1 | External drive supply selected |
| cl_raw | input | 1 | Raw line clock, synchronous to clk |
| fr_raw | input | 1 | Raw frame signal, synchronous to clk |
| cl_port_bit | input | 1 | Port data bit of the line-clock pin |
| fr_port_bit | input | 1 | Port data bit of the frame pin |
| cl_pin | output | 1 | Gated line clock |
| fr_pin | output | 1 | Gated frame signal |
| disp_mode | output | 2 | Stored display mode |
| area_sel | output | 1 | Effective display-area select |
| contrast | output | 4 | Effective contrast code |

## Verification
The assertions assume that the raw line clock and frame signal come from logic in the same clock domain. They also assume that each raw signal keeps every phase for at least one clock. The gate-hold and forced-high properties depend on these assumptions. The bench produces both raw signals from a counter that advances on the falling clock edge, with fixed periods of 8 and 32 cycles. It changes enables, port bits and sleep at many raw phases. It also measures every low phase on both pins against its full length.

// File: rtl/lcd_ctrl_pkg.sv
package lcd_ctrl_pkg;

    localparam int CON_W         = 4;
    localparam int MODE_W        = 2;
    localparam int NUM_SIG       = 2;
    localparam int SIG_CL        = 0;
    localparam int SIG_FR        = 1;

    localparam int DISP_CON_LSB  = 0;
    localparam int DISP_MODE_LSB = 4;
    localparam int DISP_AREA_BIT = 6;
    localparam int OUT_FR_BIT    = 3;
    localparam int OUT_CL_BIT    = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 2'b00,
        MODE_NORMAL = 2'b01,
        MODE_DARK   = 2'b10,
        MODE_LIT    = 2'b11
    } lcd_mode_e;

    typedef enum logic [1:0] {
        DUTY_32   = 2'b00,
        DUTY_16   = 2'b01,
        DUTY_8    = 2'b10,
        DUTY_RSVD = 2'b11
    } duty_e;

    typedef struct packed {
        logic             area;
        lcd_mode_e        mode;
        logic [CON_W-1:0] contrast;
        logic             cl_en;
        logic             fr_en;
    } lcd_regs_t;

    localparam lcd_regs_t REGS_RESET = '{
        area: 1'b0, mode: MODE_OFF, contrast: '0, cl_en: 1'b0, fr_en: 1'b0
    };

endpackage

// File: rtl/lcd_reg_file.sv
module lcd_reg_file
    import lcd_ctrl_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_OUT  = 16'hFF10,
    parameter logic [ADDR_W-1:0] ADDR_DISP = 16'hFF11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              sleep,
    output lcd_regs_t         regs,
    output logic [DATA_W-1:0] rdata
);

    lcd_regs_t regs_d, regs_q;

    logic hit_disp, hit_out;
    assign hit_disp = (addr == ADDR_DISP);
    assign hit_out  = (addr == ADDR_OUT);

    always_comb begin
        regs_d = regs_q;
        if (wr && hit_disp) begin
            regs_d.contrast = wdata[DISP_CON_LSB +: CON_W];
            regs_d.mode     = lcd_mode_e'(wdata[DISP_MODE_LSB +: MODE_W]);
            regs_d.area     = wdata[DISP_AREA_BIT];
        end
        if (wr && hit_out) begin
            regs_d.fr_en = wdata[OUT_FR_BIT];
            regs_d.cl_en = wdata[OUT_CL_BIT];
        end
        if (sleep) begin
            regs_d.mode = MODE_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RESET;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        if (hit_disp) begin
            rdata[DISP_CON_LSB +: CON_W]   = regs_q.contrast;
            rdata[DISP_MODE_LSB +: MODE_W] = regs_q.mode;
            rdata[DISP_AREA_BIT]           = regs_q.area;
        end else if (hit_out) begin
            rdata[OUT_FR_BIT] = regs_q.fr_en;
            rdata[OUT_CL_BIT] = regs_q.cl_en;
        end
    end

    assign regs = regs_q;

    AST_SLEEP_MODE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (regs_q.mode == MODE_OFF)); // R8

    AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_disp && !sleep) |=> (regs_q.mode == $past(wdata[DISP_MODE_LSB +: MODE_W]))); // R3

    AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit_disp && !hit_out && !sleep) |=> $stable(regs_q)); // R1

endmodule

// File: rtl/lcd_sig_gate.sv
module lcd_sig_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic enable,
    output logic pin
);

    typedef struct packed {
        logic gate;
        logic pin;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pin = st_q.gate ? raw : 1'b1;
        if (raw) begin
            st_d.gate = enable;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{gate: 1'b0, pin: 1'b1};
        else        st_q <= st_d;
    end

    assign pin = st_q.pin;

    AST_GATE_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !raw |=> $stable(st_q.gate)); // R7

    AST_CLOSED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.gate |=> pin); // R5

    AST_OPEN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gate |=> (pin == $past(raw))); // R6

endmodule

// File: rtl/lcd_out_map.sv
module lcd_out_map
    import lcd_ctrl_pkg::*;
(
    input  lcd_regs_t        regs,
    input  logic [1:0]       duty,
    input  logic             ext_supply,
    output logic             area_eff,
    output logic [CON_W-1:0] contrast_eff
);

    logic two_screen;

    always_comb begin
        unique case (duty_e'(duty))
            DUTY_16, DUTY_8: two_screen = 1'b1;
            default:         two_screen = 1'b0;
        endcase
        area_eff     = two_screen & regs.area;
        contrast_eff = ext_supply ? '0 : regs.contrast;
    end

endmodule

// File: rtl/lcd_ctrl_regs.sv
module lcd_ctrl_regs
    import lcd_ctrl_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_OUT  = 16'hFF10,
    parameter logic [ADDR_W-1:0] ADDR_DISP = 16'hFF11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sleep_req,
    input  logic [1:0]        duty_sel,
    input  logic              ext_supply,
    input  logic              cl_raw,
    input  logic              fr_raw,
    input  logic              cl_port_bit,
    input  logic              fr_port_bit,
    output logic              cl_pin,
    output logic              fr_pin,
    output logic [1:0]        disp_mode,
    output logic              area_sel,
    output logic [3:0]        contrast
);

    lcd_regs_t           regs;
    logic [NUM_SIG-1:0]  raw_v, en_v, pin_v, port_v, reg_en_v;

    lcd_reg_file #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_OUT(ADDR_OUT), .ADDR_DISP(ADDR_DISP)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .wr(bus_wr), .sleep(sleep_req), .regs(regs), .rdata(bus_rdata)
    );

    assign raw_v[SIG_CL]    = cl_raw;
    assign raw_v[SIG_FR]    = fr_raw;
    assign port_v[SIG_CL]   = cl_port_bit;
    assign port_v[SIG_FR]   = fr_port_bit;
    assign reg_en_v[SIG_CL] = regs.cl_en;
    assign reg_en_v[SIG_FR] = regs.fr_en;

    for (genvar g = 0; g < NUM_SIG; g++) begin : g_gate
        assign en_v[g] = reg_en_v[g] & port_v[g] & ~sleep_req;
        lcd_sig_gate u_gate (
            .clk(clk), .rst_n(rst_n), .raw(raw_v[g]), .enable(en_v[g]), .pin(pin_v[g])
        );
    end

    assign cl_pin    = pin_v[SIG_CL];
    assign fr_pin    = pin_v[SIG_FR];
    assign disp_mode = regs.mode;

    lcd_out_map u_map (
        .regs(regs), .duty(duty_sel), .ext_supply(ext_supply),
        .area_eff(area_sel), .contrast_eff(contrast)
    );

    AST_AREA_ONE_SCREEN: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_sel == DUTY_32 || duty_sel == DUTY_RSVD) |-> !area_sel); // R4

    AST_EXT_CONTRAST: assert property (@(posedge clk) disable iff (!rst_n)
        ext_supply |-> (contrast == '0)); // R10

    AST_SLEEP_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && cl_pin && cl_raw) |=> cl_pin); // R9

endmodule

// File: tb/lcd_ctrl_regs_bench.sv
module lcd_ctrl_regs_bench;
    import lcd_ctrl_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SEL_CL = 0, SEL_FR = 1, SEL_MODE = 2, SEL_AREA = 3, SEL_CON = 4, SEL_RD = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic        bus_wr = 1'b0, sleep_req = 1'b0, ext_supply = 1'b0;
    logic [1:0]  duty_sel = 2'b00;
    logic        cl_port_bit = 1'b1, fr_port_bit = 1'b1;
    logic        cl_pin, fr_pin, area_sel;
    logic [1:0]  disp_mode;
    logic [3:0]  contrast;
    logic [7:0]  ph = '0;
    logic        cl_raw, fr_raw;

    always @(negedge clk) ph <= ph + 8'd1;
    assign cl_raw = ~ph[2];
    assign fr_raw = ~ph[4];

    lcd_ctrl_regs u_lcd_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
        .duty_sel(duty_sel), .ext_supply(ext_supply), .cl_raw(cl_raw), .fr_raw(fr_raw),
        .cl_port_bit(cl_port_bit), .fr_port_bit(fr_port_bit), .cl_pin(cl_pin),
        .fr_pin(fr_pin), .disp_mode(disp_mode), .area_sel(area_sel), .contrast(contrast)
    );

    typedef struct {
        string req;
        int    sel;
        int    exp;
        int    due;
    } item_t;

    item_t sb[$];
    int cyc = 0, checks = 0, errors = 0;
    int cl_low = 0, fr_low = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int probe(int sel);
        case (sel)
            SEL_CL:   return int'(cl_pin);
            SEL_FR:   return int'(fr_pin);
            SEL_MODE: return int'(disp_mode);
            SEL_AREA: return int'(area_sel);
            SEL_CON:  return int'(contrast);
            default:  return int'(bus_rdata);
        endcase
    endfunction

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            int act;
            it  = sb.pop_front();
            act = probe(it.sel);
            checks++;
            if (act != it.exp) begin
                errors++;
                $display("FAIL %s (probe %0d): actual %0d expected %0d", it.req, it.sel, act, it.exp);
            end
        end
        if (rst_n) begin
            if (!cl_pin) cl_low++;
            else if (cl_low > 0) begin
                checks++;
                if (cl_low != 4) begin
                    errors++;
                    $display("FAIL R7 cl low phase: actual %0d expected 4", cl_low);
                end
                cl_low = 0;
            end
            if (!fr_pin) fr_low++;
            else if (fr_low > 0) begin
                checks++;
                if (fr_low != 16) begin
                    errors++;
                    $display("FAIL R7 fr low phase: actual %0d expected 16", fr_low);
                end
                fr_low = 0;
            end
        end
    end

    task automatic chk(string req, int sel, int exp);
        sb.push_back('{req: req, sel: sel, exp: exp, due: cyc + 1});
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) settle();
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        settle();
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [15:0] a, int exp);
        bus_addr = a;
        chk(req, SEL_RD, exp);
        settle();
    endtask

    task automatic wait_ph(int p);
        while (int'(ph[2:0]) != p) settle();
    endtask

    task automatic follow(string req, int n);
        for (int i = 0; i < n; i++) begin
            chk(req, SEL_CL, int'(cl_raw));
            chk(req, SEL_FR, int'(fr_raw));
            settle();
        end
    endtask

    task automatic hold_high(string req, int sel, int n);
        for (int i = 0; i < n; i++) begin
            chk(req, sel, 1);
            settle();
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        wait_cycles(3);
        // R11: reset state
        chk("R11", SEL_CL, 1); chk("R11", SEL_FR, 1); chk("R11", SEL_MODE, 0);
        chk("R11", SEL_AREA, 0); chk("R11", SEL_CON, 0);
        settle();
        rd_chk("R11", 16'hFF11, 0);
        rd_chk("R11", 16'hFF10, 0);
        rst_n = 1'b1;
        settle();

        // R1 R3 R2: field placement, mode 01
        duty_sel = DUTY_16;
        wr(16'hFF11, 8'h5A);
        chk("R3", SEL_MODE, 1); chk("R1", SEL_CON, 10); chk("R1", SEL_AREA, 1);
        settle();
        rd_chk("R2", 16'hFF11, 8'h5A);
        wr(16'hFF12, 8'hFF);
        rd_chk("R1", 16'hFF11, 8'h5A);
        rd_chk("R1", 16'hFF10, 8'h00);
        rd_chk("R2", 16'hFF12, 0);

        // R4: area select against duty
        duty_sel = DUTY_8;    chk("R4", SEL_AREA, 1); settle();
        duty_sel = DUTY_32;   chk("R4", SEL_AREA, 0); settle();
        duty_sel = DUTY_RSVD; chk("R4", SEL_AREA, 0); settle();
        duty_sel = DUTY_16;   chk("R4", SEL_AREA, 1); settle();

        // R10: external supply hides contrast
        ext_supply = 1'b1; chk("R10", SEL_CON, 0); settle();
        rd_chk("R10", 16'hFF11, 8'h5A);
        ext_supply = 1'b0; chk("R10", SEL_CON, 10); settle();

        // R3 R2: remaining mode codes, unused bit 7
        wr(16'hFF11, 8'hFF); chk("R3", SEL_MODE, 3); settle();
        rd_chk("R2", 16'hFF11, 8'h7F);
        wr(16'hFF11, 8'h20); chk("R3", SEL_MODE, 2); chk("R1", SEL_CON, 0); settle();
        wr(16'hFF11, 8'h00); chk("R3", SEL_MODE, 0); settle();

        // R5: disabled pins stay high
        hold_high("R5", SEL_CL, 16);
        hold_high("R5", SEL_FR, 16);

        // R6: enabled pins follow raw
        wr(16'hFF10, 8'hFF);
        rd_chk("R2", 16'hFF10, 8'h18);
        wait_cycles(40);
        follow("R6", 40);

        // R5: port bit low closes gate
        cl_port_bit = 1'b0;
        wait_cycles(10);
        for (int i = 0; i < 16; i++) begin
            chk("R5", SEL_CL, 1);
            chk("R6", SEL_FR, int'(fr_raw));
            settle();
        end
        cl_port_bit = 1'b1;
        wait_cycles(10);

        // R7: disable during low phase waits for high
        wait_ph(4);
        wr(16'hFF10, 8'h08);
        chk("R7", SEL_CL, 0); settle();
        chk("R7", SEL_CL, 0); settle();
        chk("R7", SEL_CL, 0); settle();
        hold_high("R7", SEL_CL, 16);

        // R7: enable during low phase keeps pin high for that phase
        wait_ph(4);
        wr(16'hFF10, 8'h18);
        chk("R7", SEL_CL, 1); settle();
        chk("R7", SEL_CL, 1); settle();
        chk("R7", SEL_CL, 1); settle();
        wait_ph(5);
        chk("R7", SEL_CL, 0); settle();

        // R7: toggle enables at many phases; low phase monitor checks widths
        for (int i = 0; i < 120; i++) begin
            wr(16'hFF10, (i % 3 == 0) ? 8'h00 : ((i % 3 == 1) ? 8'h10 : 8'h18));
            wait_cycles(i % 7);
        end
        wr(16'hFF10, 8'h18);
        wait_cycles(40);

        // R8 R9: sleep
        wr(16'hFF11, 8'h5A);
        sleep_req = 1'b1;
        chk("R8", SEL_MODE, 0); settle();
        rd_chk("R8", 16'hFF11, 8'h4A);
        wr(16'hFF11, 8'h7B);
        rd_chk("R8", 16'hFF11, 8'h4B);
        wait_cycles(40);
        for (int i = 0; i < 40; i++) begin
            chk("R9", SEL_CL, 1);
            chk("R9", SEL_FR, 1);
            settle();
        end
        sleep_req = 1'b0;
        chk("R8", SEL_MODE, 0); settle();
        wait_cycles(40);
        follow("R9", 40);
        wr(16'hFF11, 8'h15); chk("R8", SEL_MODE, 1); settle();

        wait_cycles(4);
        summary();
    end

endmodule